// File: doc/BRIEF.md
# Registered Multiport Bus Exchanger

This block moves data between four narrow ports (A, B, C, D) and two far-side ports (X, Y). Each narrow port has two registers. The input register captures data arriving on the narrow port. The output register captures data from the far side: X feeds the registers of A and C, and Y feeds those of B and D. A two-bit select decides what each narrow port drives:

- its own input register (readback);
- its own output register (clocked path);
- X broadcast to all four ports;
- a split, with X going to A and C and Y going to B and D.

Tristate pads are modelled as a data-out bus plus per-port drive enables. An active-low output-enable control sets those enables.

Control inputs come in two groups. The output-enable control forms one group. The select and the input-register load strobes form the other. Each group has its own mode pin:

- With the mode pin low, the group's raw inputs act directly.
- With the mode pin high, the group follows a shadow register that captures the raw inputs on every rising edge of a separate control clock.

Because the shadows capture on every edge, one control-clock edge taken before the mode pin rises presets them to the current inputs. The change of mode then leaves the effective controls unchanged. The output-register load strobes always act directly.

Top module: `bx_exchanger`

## Requirements
- R1: With `oe_n_i` low, the effective enable is active and every bit of `a_oe_o` is 1. With it high, every bit of `a_oe_o` is 0. Input-register loading works the same in both cases.
- R2: Select value 2'b00 drives each narrow lane of `a_o` from that lane's input register. Lane k occupies bits [k*W +: W], with A=0, B=1, C=2 and D=3.
- R3: Select value 2'b01 drives each lane from that lane's output register.
- R4: Select value 2'b10 drives all four lanes with `x_i`, combinationally.
- R5: Select value 2'b11 drives lanes A and C with `x_i` and lanes B and D with `y_i`, combinationally.
- R6: On a rising `clk_i` edge, the input register of lane k loads lane k of `a_i` when bit k of the effective active-low load is 0. Otherwise it holds its value.
- R7: On a rising `clk_i` edge, the output register of lane k loads from the far side when bit k of `ld_out_n_i` is 0. Lanes A and C load from `x_i`; lanes B and D load from `y_i`.
- R8: With a group's mode pin low, that group's raw inputs take effect without any control-clock edge. `oe_mode_i` governs the enable group. `sc_mode_i` governs the select and input loads.
- R9: With a group's mode pin high, raw changes have no effect until the next rising `ctl_clk_i` edge. From that edge on, the sampled values act as they would in direct mode. A shadow preset by a control-clock edge makes the rise of the mode pin glitch-free.
- R10: `rst_ni` low clears every data register to 0. It resets the shadows to: enable inactive, select 2'b00, and no input load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data clock for the input and output registers |
| ctl_clk_i | input | 1 | Control clock for the shadow control registers |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oe_mode_i | input | 1 | 1: enable group uses its shadow; 0: direct |
| sc_mode_i | input | 1 | 1: select and load group uses its shadow; 0: direct |
| oe_n_i | input | 1 | Active-low output enable for the narrow ports |
| sel_i | input | 2 | Narrow-port source select |
| ld_in_n_i | input | 4 | Active-low input-register loads, one per lane |
| ld_out_n_i | input | 4 | Active-low output-register loads, one per lane |
| a_i | input | 4*W | Data arriving on the narrow ports |
| x_i | input | W | Far-side port X |
| y_i | input | W | Far-side port Y |
| a_o | output | 4*W | Data driven onto the narrow ports |
| a_oe_o | output | 4 | Drive enable per narrow port |

## Verification
The following are checked on every cycle in direct mode:

- the enable level;
- the broadcast and split transparent paths;
- input-register load and hold of lane A;
- output-register load of lane A.

The enable shadow is also checked on every control-clock edge, which covers one control-clock cycle of latency. Only the bench scenarios show two things: that a preset shadow makes the mode switch glitch-free, and that a raw select or load change stays ignored until the control edge. They also cover per-lane isolation of partial loads, loading while the drivers are disabled, and the reset values of the shadows.

// File: rtl/bx_pkg.sv
package bx_pkg;
  localparam int unsigned NPORT = 4;

  typedef enum logic [1:0] {
    SEL_READBACK = 2'b00,
    SEL_CLOCKED  = 2'b01,
    SEL_BCAST    = 2'b10,
    SEL_SPLIT    = 2'b11
  } bx_sel_e;
endpackage

// File: rtl/bx_ctl_shadow.sv
module bx_ctl_shadow #(
  parameter int unsigned    WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             ctl_clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] eff_o
);
  logic [WIDTH-1:0] shadow_q;

  // captures on every edge so a preset precedes any mode change
  always_ff @(posedge ctl_clk_i or negedge rst_ni) begin
    if (!rst_ni) shadow_q <= RST_VAL;
    else         shadow_q <= raw_i;
  end

  assign eff_o = mode_i ? shadow_q : raw_i;
endmodule

// File: rtl/bx_lane.sv
module bx_lane
  import bx_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter bit          FROM_Y = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         ld_in_n_i,
  input  logic         ld_out_n_i,
  input  bx_sel_e      sel_i,
  output logic [W-1:0] drv_o
);
  logic [W-1:0] in_q, out_q, far;

  assign far = FROM_Y ? y_i : x_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      out_q <= '0;
    end else begin
      if (!ld_in_n_i)  in_q  <= a_i;
      if (!ld_out_n_i) out_q <= far;
    end
  end

  always_comb begin
    drv_o = in_q;
    unique case (sel_i)
      SEL_READBACK: drv_o = in_q;
      SEL_CLOCKED:  drv_o = out_q;
      SEL_BCAST:    drv_o = x_i;
      SEL_SPLIT:    drv_o = far;
      default:      drv_o = in_q;
    endcase
  end
endmodule

// File: rtl/bx_exchanger.sv
module bx_exchanger
  import bx_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic               clk_i,
  input  logic               ctl_clk_i,
  input  logic               rst_ni,
  input  logic               oe_mode_i,
  input  logic               sc_mode_i,
  input  logic               oe_n_i,
  input  logic [1:0]         sel_i,
  input  logic [NPORT-1:0]   ld_in_n_i,
  input  logic [NPORT-1:0]   ld_out_n_i,
  input  logic [NPORT*W-1:0] a_i,
  input  logic [W-1:0]       x_i,
  input  logic [W-1:0]       y_i,
  output logic [NPORT*W-1:0] a_o,
  output logic [NPORT-1:0]   a_oe_o
);
  logic             oe_n_eff;
  logic [1:0]       sel_eff;
  logic [NPORT-1:0] ld_in_n_eff;

  bx_ctl_shadow #(.WIDTH(1), .RST_VAL(1'b1)) u_oe_sh (
    .ctl_clk_i(ctl_clk_i), .rst_ni(rst_ni), .mode_i(oe_mode_i),
    .raw_i(oe_n_i), .eff_o(oe_n_eff)
  );

  bx_ctl_shadow #(.WIDTH(2), .RST_VAL(2'b00)) u_sel_sh (
    .ctl_clk_i(ctl_clk_i), .rst_ni(rst_ni), .mode_i(sc_mode_i),
    .raw_i(sel_i), .eff_o(sel_eff)
  );

  bx_ctl_shadow #(.WIDTH(NPORT), .RST_VAL({NPORT{1'b1}})) u_ld_sh (
    .ctl_clk_i(ctl_clk_i), .rst_ni(rst_ni), .mode_i(sc_mode_i),
    .raw_i(ld_in_n_i), .eff_o(ld_in_n_eff)
  );

  for (genvar k = 0; k < NPORT; k++) begin : g_lane
    // lanes A and C pair with X, B and D with Y
    bx_lane #(.W(W), .FROM_Y(k % 2 == 1)) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .a_i        (a_i[k*W +: W]),
      .x_i        (x_i),
      .y_i        (y_i),
      .ld_in_n_i  (ld_in_n_eff[k]),
      .ld_out_n_i (ld_out_n_i[k]),
      .sel_i      (bx_sel_e'(sel_eff)),
      .drv_o      (a_o[k*W +: W])
    );
    assign a_oe_o[k] = ~oe_n_eff;
  end
endmodule

// File: rtl/bx_exchanger_chk.sv
module bx_exchanger_chk #(
  parameter int unsigned W = 8
) (
  input logic           clk_i,
  input logic           ctl_clk_i,
  input logic           rst_ni,
  input logic           oe_mode_i,
  input logic           sc_mode_i,
  input logic           oe_n_i,
  input logic [1:0]     sel_i,
  input logic [3:0]     ld_in_n_i,
  input logic [3:0]     ld_out_n_i,
  input logic [4*W-1:0] a_i,
  input logic [W-1:0]   x_i,
  input logic [W-1:0]   y_i,
  input logic [4*W-1:0] a_o,
  input logic [3:0]     a_oe_o
);
  AST_OE_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_mode_i |-> a_oe_o == {4{~oe_n_i}}); // R1 R8

  AST_OE_SHADOW: assert property (@(posedge ctl_clk_i) disable iff (!rst_ni)
    (oe_mode_i && $past(rst_ni)) |-> a_oe_o == {4{~$past(oe_n_i)}}); // R9

  AST_BCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sc_mode_i && sel_i == 2'b10) |-> a_o == {4{x_i}}); // R4

  AST_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sc_mode_i && sel_i == 2'b11) |-> a_o == {y_i, x_i, y_i, x_i}); // R5

  AST_IN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sc_mode_i && sel_i == 2'b00 && $past(rst_ni && !sc_mode_i && !ld_in_n_i[0]))
      |-> a_o[W-1:0] == $past(a_i[W-1:0])); // R6

  AST_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sc_mode_i && sel_i == 2'b00 && $past(rst_ni)
      && $past(!sc_mode_i && sel_i == 2'b00 && ld_in_n_i[0]))
      |-> $stable(a_o[W-1:0])); // R2

  AST_OUT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sc_mode_i && sel_i == 2'b01 && $past(rst_ni && !ld_out_n_i[0]))
      |-> a_o[W-1:0] == $past(x_i)); // R7
endmodule

bind bx_exchanger bx_exchanger_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .ctl_clk_i(ctl_clk_i), .rst_ni(rst_ni),
  .oe_mode_i(oe_mode_i), .sc_mode_i(sc_mode_i), .oe_n_i(oe_n_i),
  .sel_i(sel_i), .ld_in_n_i(ld_in_n_i), .ld_out_n_i(ld_out_n_i),
  .a_i(a_i), .x_i(x_i), .y_i(y_i), .a_o(a_o), .a_oe_o(a_oe_o)
);

// File: tb/bx_exchanger_test.sv
module bx_exchanger_test;
  localparam int unsigned W = 8;

  logic           clk_i = 1'b0, ctl_clk_i = 1'b0, rst_ni = 1'b0;
  logic           oe_mode_i = 1'b0, sc_mode_i = 1'b0, oe_n_i = 1'b1;
  logic [1:0]     sel_i = 2'b00;
  logic [3:0]     ld_in_n_i = 4'hF, ld_out_n_i = 4'hF;
  logic [4*W-1:0] a_i = '0;
  logic [W-1:0]   x_i = '0, y_i = '0;
  logic [4*W-1:0] a_o;
  logic [3:0]     a_oe_o;

  int checks = 0, errors = 0;
  logic [4*W-1:0] exp_in;

  bx_exchanger #(.W(W)) uut (.*);

  always #10 clk_i = ~clk_i;
  initial begin #5 ctl_clk_i = 1'b1; forever #10 ctl_clk_i = ~ctl_clk_i; end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic dclk(); @(posedge clk_i); #1; endtask
  task automatic cclk(); @(posedge ctl_clk_i); #1; endtask

  task automatic t_reset();
    chk("R10 a_o", a_o, 0);
    chk("R10 a_oe_o", a_oe_o, 0);
    oe_mode_i = 1'b1; oe_n_i = 1'b0; #1;
    chk("R10 oe shadow inactive", a_oe_o, 0);
    oe_mode_i = 1'b0; #1;
    chk("R8 direct oe", a_oe_o, 4'hF);
    oe_n_i = 1'b1; #1;
  endtask

  task automatic t_in_regs();
    sel_i = 2'b00; a_i = 32'h44332211; ld_in_n_i = 4'h0; dclk();
    ld_in_n_i = 4'hF;
    chk("R2 R6 full load", a_o, 32'h44332211);
    a_i = 32'hDDCCBBAA; dclk();
    chk("R6 hold", a_o, 32'h44332211);
    ld_in_n_i = 4'b1011; dclk(); ld_in_n_i = 4'hF;
    chk("R6 lane C only", a_o, 32'h44CC2211);
    exp_in = 32'h44CC2211;
  endtask

  task automatic t_out_regs();
    x_i = 8'h3C; y_i = 8'hA5; ld_out_n_i = 4'h0; dclk(); ld_out_n_i = 4'hF;
    sel_i = 2'b01; #1;
    chk("R3 R7 clocked path", a_o, {8'hA5, 8'h3C, 8'hA5, 8'h3C});
    x_i = 8'h0F; y_i = 8'hF0; ld_out_n_i = 4'b1101; dclk(); ld_out_n_i = 4'hF;
    chk("R7 lane B only from Y", a_o, {8'hA5, 8'h3C, 8'hF0, 8'h3C});
    sel_i = 2'b00; #1;
    chk("R2 readback unchanged", a_o, exp_in);
  endtask

  task automatic t_transparent();
    x_i = 8'h5A; y_i = 8'hC3; sel_i = 2'b10; #1;
    chk("R4 broadcast", a_o, {4{8'h5A}});
    x_i = 8'h77; #1;
    chk("R4 transparent change", a_o, {4{8'h77}});
    sel_i = 2'b11; #1;
    chk("R5 split", a_o, {8'hC3, 8'h77, 8'hC3, 8'h77});
    y_i = 8'h19; #1;
    chk("R5 split Y change", a_o, {8'h19, 8'h77, 8'h19, 8'h77});
    sel_i = 2'b00; #1;
  endtask

  task automatic t_oe();
    oe_n_i = 1'b0; #1;
    chk("R1 enabled", a_oe_o, 4'hF);
    oe_n_i = 1'b1; a_i = 32'h87654321; ld_in_n_i = 4'h0; dclk(); ld_in_n_i = 4'hF;
    chk("R1 disabled", a_oe_o, 4'h0);
    chk("R1 load while disabled", a_o, 32'h87654321);
    exp_in = 32'h87654321;
  endtask

  task automatic t_sync_oe();
    oe_n_i = 1'b0; cclk();
    oe_mode_i = 1'b1; #1;
    chk("R9 preset no glitch", a_oe_o, 4'hF);
    oe_n_i = 1'b1; #1;
    chk("R9 raw ignored", a_oe_o, 4'hF);
    cclk();
    chk("R9 sampled oe", a_oe_o, 4'h0);
    oe_mode_i = 1'b0; #1;
  endtask

  task automatic t_sync_sc();
    x_i = 8'h6B; sel_i = 2'b10; cclk();
    sc_mode_i = 1'b1; #1;
    chk("R9 sel preset", a_o, {4{8'h6B}});
    sel_i = 2'b00; #1;
    chk("R9 sel raw ignored", a_o, {4{8'h6B}});
    cclk();
    chk("R9 sel sampled", a_o, exp_in);
    ld_in_n_i = 4'h0; a_i = 32'h0BADF00D;
    dclk();
    chk("R9 load raw ignored", a_o, exp_in);
    cclk(); dclk();
    chk("R9 R6 sampled load", a_o, 32'h0BADF00D);
    ld_in_n_i = 4'hF; a_i = 32'h12345678;
    cclk(); dclk();
    chk("R9 sampled hold", a_o, 32'h0BADF00D);
    sc_mode_i = 1'b0; #1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1; #1;
    t_reset();
    t_in_regs();
    t_out_regs();
    t_transparent();
    t_oe();
    t_sync_oe();
    t_sync_sc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule